// File: doc/BRIEF.md
# Holdover Entry/Exit Controller

This controller sits beside the first loop of a two-loop clock cleaner. It decides when that loop stops following its reference and coasts in holdover, and when it goes back to normal locking. A master enable gates all entry. On top of it, four separate triggers can each be switched on: loss of loop lock, loss of reference (which also needs the loss-of-signal detector enabled), a tuning-voltage code outside a programmable window, and a software force request.

While the loop is locked and no trigger is active, the block keeps a copy of the digitized tuning-voltage code. In holdover the charge pump is turned off. The oscillator control DAC can then be overridden with either a programmed manual code or the last tracked code; the manual code wins if both are enabled. When all triggers clear, the block re-enables the charge pump straight away. With the hitless option set, it first waits for the reference-divider and feedback-divider pulses to line up within a programmable number of cycles.

Top module: `holdover_sequencer`

## Requirements
- R1: While `cfgHoldEn` is 0 the block never enters holdover from the locked state, whatever the triggers and `forceHold` show.
- R2: With `cfgHoldEn` and `cfgLockTrig` both 1, a 0 on `loopLocked` at a clock edge sets `holdActive` to 1 after that edge. With `cfgLockTrig` at 0, loss of lock has no effect.
- R3: A 1 on `refLost` causes entry only when `cfgHoldEn`, `cfgLosTrig` and `cfgLosDetEn` are all 1.
- R4: With `cfgVtuneTrig` set, entry happens when `tuneCode < tripLow` or `tuneCode > tripHigh` (unsigned). A code equal to either limit is inside the window.
- R5: With `cfgHoldEn` set, `forceHold` at 1 causes entry after the next edge, whatever the other triggers show.
- R6: `cpEnable` is 0 and `holdActive` is 1 in every cycle the block is in holdover or waiting for alignment. In the locked state `cpEnable` is 1 and `holdActive` is 0.
- R7: The tracked code is captured on each edge where the block is locked, `loopLocked` is 1 and no trigger is active. In holdover with `cfgTrackEn` set and `cfgManualEn` clear, `dacOverride` shows the last captured code and stays constant.
- R8: In holdover with `cfgManualEn` set, `dacOvrEn` is 1 and `dacOverride` equals `manualCode`, even when tracking is also on. `dacOvrEn` is 0 and `dacOverride` is 0 when not in holdover or when neither mode is enabled.
- R9: With `cfgHitless` at 0, the block is locked again one edge after the triggers clear.
- R10: With `cfgHitless` at 1, clearing the triggers moves the block into an alignment-wait state. It stays there until a reference pulse and a feedback pulse arrive no more than `alignWin` cycles apart, with the later pulse seen in that state, and then it returns to locked on that edge. A trigger during the wait sends the block back to holdover.
- R11: After reset the block is locked: `holdActive` 0, `cpEnable` 1, `dacOvrEn` 0, `dacOverride` 0, and the tracked code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgHoldEn | input | 1 | Master holdover enable |
| cfgLockTrig | input | 1 | Enter holdover on loss of lock |
| cfgLosTrig | input | 1 | Enter holdover on reference loss |
| cfgLosDetEn | input | 1 | Loss-of-signal detector enabled |
| cfgVtuneTrig | input | 1 | Enter holdover on tuning code outside window |
| cfgHitless | input | 1 | Wait for divider phase alignment before exit |
| cfgTrackEn | input | 1 | Override DAC with tracked code in holdover |
| cfgManualEn | input | 1 | Override DAC with manual code in holdover |
| forceHold | input | 1 | Force holdover |
| loopLocked | input | 1 | Loop lock indicator |
| refLost | input | 1 | Reference loss flag |
| tuneCode | input | CODE_W | Digitized tuning voltage |
| tripLow | input | CODE_W | Lower window limit |
| tripHigh | input | CODE_W | Upper window limit |
| manualCode | input | CODE_W | Programmed manual DAC code |
| alignWin | input | WIN_W | Alignment window in cycles |
| refPulse | input | 1 | Reference divider output pulse |
| fbPulse | input | 1 | Feedback divider output pulse |
| holdActive | output | 1 | Holdover or alignment wait active |
| cpEnable | output | 1 | Charge-pump enable |
| dacOvrEn | output | 1 | DAC override valid |
| dacOverride | output | CODE_W | DAC override code |

## Verification
A wrong state register shows up at once on `holdActive` and `cpEnable`, one edge after the stimulus that should have moved it. The bench therefore compares those two outputs on every cycle against hand-derived expectations. A tracked code captured at the wrong time shows only once holdover starts, as a wrong `dacOverride` value. So each tracking check first sets a known code while locked and then changes the code during the entry cycle. Alignment-counter errors show as an exit one cycle early or late, and the bench probes them with pulse gaps exactly at and one past the window.

// File: rtl/holdover_pkg.sv
package holdover_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED     = 2'd0,
    ST_HOLDOVER   = 2'd1,
    ST_WAIT_ALIGN = 2'd2
  } holdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureEn;  // sample tuning code this edge
    logic holdMode;   // loop is not in normal locking
  } ctrlStrobe_t;

endpackage

// File: rtl/holdover_pulse_age.sv
// Cycles elapsed since the last pulse, saturating at all ones.
module holdover_pulse_age #(
  parameter int WIN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  output logic [WIN_W-1:0] age
);
  localparam logic [WIN_W-1:0] AGE_SAT = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= AGE_SAT;
    else if (pulse)       age <= '0;
    else if (age != AGE_SAT) age <= age + 1'b1;
  end
endmodule

// File: rtl/holdover_datapath.sv
module holdover_datapath
  import holdover_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strobe,
  input  logic [CODE_W-1:0] tuneCode,
  input  logic [CODE_W-1:0] tripLow,
  input  logic [CODE_W-1:0] tripHigh,
  input  logic [CODE_W-1:0] manualCode,
  input  logic              cfgTrackEn,
  input  logic              cfgManualEn,
  input  logic [WIN_W-1:0]  alignWin,
  input  logic              refPulse,
  input  logic              fbPulse,
  output logic              outWindow,
  output logic              phaseAligned,
  output logic              dacOvrEn,
  output logic [CODE_W-1:0] dacOverride
);
  localparam int NUM_PATHS = 2;

  logic [CODE_W-1:0] trackVal;
  logic [NUM_PATHS-1:0] pulseVec;
  logic [WIN_W-1:0] ageVec [NUM_PATHS];

  // window compare on the tuning code
  assign outWindow = (tuneCode < tripLow) || (tuneCode > tripHigh);

  // tracked tuning value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               trackVal <= '0;
    else if (strobe.captureEn) trackVal <= tuneCode;
  end

  // divider pulse ages, index 0 reference, 1 feedback
  assign pulseVec = {fbPulse, refPulse};
  for (genvar gi = 0; gi < NUM_PATHS; gi++) begin : g_age
    holdover_pulse_age #(.WIN_W(WIN_W)) u_age (
      .clk  (clk),
      .rst_n(rst_n),
      .pulse(pulseVec[gi]),
      .age  (ageVec[gi])
    );
  end

  // a pulse now pairs with the other path's pulse now or within alignWin cycles back
  always_comb begin
    phaseAligned = 1'b0;
    if (refPulse && (fbPulse || (ageVec[1] < alignWin))) phaseAligned = 1'b1;
    if (fbPulse && (ageVec[0] < alignWin))               phaseAligned = 1'b1;
  end

  // DAC override selection, manual has priority over tracked
  always_comb begin
    dacOvrEn    = strobe.holdMode && (cfgManualEn || cfgTrackEn);
    dacOverride = '0;
    if (strobe.holdMode) begin
      if (cfgManualEn)     dacOverride = manualCode;
      else if (cfgTrackEn) dacOverride = trackVal;
    end
  end
endmodule

// File: rtl/holdover_fsm.sv
module holdover_fsm
  import holdover_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgHoldEn,
  input  logic        cfgLockTrig,
  input  logic        cfgLosTrig,
  input  logic        cfgLosDetEn,
  input  logic        cfgVtuneTrig,
  input  logic        cfgHitless,
  input  logic        forceHold,
  input  logic        loopLocked,
  input  logic        refLost,
  input  logic        outWindow,
  input  logic        phaseAligned,
  output ctrlStrobe_t strobe,
  output logic        holdActive,
  output logic        cpEnable
);
  holdState_t state, stateNext;
  logic trigger;

  always_comb begin
    trigger = cfgHoldEn && (forceHold
            || (cfgLockTrig && !loopLocked)
            || (cfgLosTrig && cfgLosDetEn && refLost)
            || (cfgVtuneTrig && outWindow));
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_LOCKED:     if (trigger) stateNext = ST_HOLDOVER;
      ST_HOLDOVER:   if (!trigger) stateNext = cfgHitless ? ST_WAIT_ALIGN : ST_LOCKED;
      ST_WAIT_ALIGN: begin
        if (trigger)           stateNext = ST_HOLDOVER;
        else if (phaseAligned) stateNext = ST_LOCKED;
      end
      default:       stateNext = ST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOCKED;
    else        state <= stateNext;
  end

  assign strobe.captureEn = (state == ST_LOCKED) && loopLocked && !trigger;
  assign strobe.holdMode  = (state != ST_LOCKED);
  assign holdActive       = (state != ST_LOCKED);
  assign cpEnable         = (state == ST_LOCKED);
endmodule

// File: rtl/holdover_sequencer.sv
module holdover_sequencer
  import holdover_pkg::*;
#(
  parameter int CODE_W = 10,
  parameter int WIN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgHoldEn,
  input  logic              cfgLockTrig,
  input  logic              cfgLosTrig,
  input  logic              cfgLosDetEn,
  input  logic              cfgVtuneTrig,
  input  logic              cfgHitless,
  input  logic              cfgTrackEn,
  input  logic              cfgManualEn,
  input  logic              forceHold,
  input  logic              loopLocked,
  input  logic              refLost,
  input  logic [CODE_W-1:0] tuneCode,
  input  logic [CODE_W-1:0] tripLow,
  input  logic [CODE_W-1:0] tripHigh,
  input  logic [CODE_W-1:0] manualCode,
  input  logic [WIN_W-1:0]  alignWin,
  input  logic              refPulse,
  input  logic              fbPulse,
  output logic              holdActive,
  output logic              cpEnable,
  output logic              dacOvrEn,
  output logic [CODE_W-1:0] dacOverride
);
  ctrlStrobe_t strobe;
  logic outWindow;
  logic phaseAligned;

  holdover_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgHoldEn   (cfgHoldEn),
    .cfgLockTrig (cfgLockTrig),
    .cfgLosTrig  (cfgLosTrig),
    .cfgLosDetEn (cfgLosDetEn),
    .cfgVtuneTrig(cfgVtuneTrig),
    .cfgHitless  (cfgHitless),
    .forceHold   (forceHold),
    .loopLocked  (loopLocked),
    .refLost     (refLost),
    .outWindow   (outWindow),
    .phaseAligned(phaseAligned),
    .strobe      (strobe),
    .holdActive  (holdActive),
    .cpEnable    (cpEnable)
  );

  holdover_datapath #(.CODE_W(CODE_W), .WIN_W(WIN_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .tuneCode    (tuneCode),
    .tripLow     (tripLow),
    .tripHigh    (tripHigh),
    .manualCode  (manualCode),
    .cfgTrackEn  (cfgTrackEn),
    .cfgManualEn (cfgManualEn),
    .alignWin    (alignWin),
    .refPulse    (refPulse),
    .fbPulse     (fbPulse),
    .outWindow   (outWindow),
    .phaseAligned(phaseAligned),
    .dacOvrEn    (dacOvrEn),
    .dacOverride (dacOverride)
  );
endmodule

// File: rtl/holdover_sequencer_chk.sv
module holdover_sequencer_chk #(
  parameter int CODE_W = 10,
  parameter int WIN_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfgHoldEn,
  input logic              cfgLockTrig,
  input logic              cfgHitless,
  input logic              cfgTrackEn,
  input logic              cfgManualEn,
  input logic              forceHold,
  input logic              loopLocked,
  input logic [CODE_W-1:0] manualCode,
  input logic [WIN_W-1:0]  alignWin,
  input logic              holdActive,
  input logic              cpEnable,
  input logic              dacOvrEn,
  input logic [CODE_W-1:0] dacOverride
);
  p_no_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!holdActive && !cfgHoldEn) |=> !holdActive);

  p_lock_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgHoldEn && cfgLockTrig && !loopLocked) |=> holdActive);

  p_force_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgHoldEn && forceHold) |=> (holdActive && !cpEnable));

  p_cp_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    holdActive |-> !cpEnable);

  p_track_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdActive && $past(holdActive) && cfgTrackEn && !cfgManualEn
     && $past(cfgTrackEn) && !$past(cfgManualEn)) |-> $stable(dacOverride));

  p_manual_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (holdActive && cfgManualEn) |-> (dacOvrEn && dacOverride == manualCode));

  p_plain_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (holdActive && !cfgHoldEn && !cfgHitless) |=> !holdActive);

  always_comb begin
    if (rst_n && !holdActive) a_no_ovr_r8: assert (!dacOvrEn);
  end

  logic unusedWin;
  assign unusedWin = ^alignWin;
endmodule

bind holdover_sequencer holdover_sequencer_chk #(.CODE_W(CODE_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfgHoldEn(cfgHoldEn), .cfgLockTrig(cfgLockTrig),
  .cfgHitless(cfgHitless), .cfgTrackEn(cfgTrackEn), .cfgManualEn(cfgManualEn),
  .forceHold(forceHold), .loopLocked(loopLocked), .manualCode(manualCode),
  .alignWin(alignWin), .holdActive(holdActive), .cpEnable(cpEnable),
  .dacOvrEn(dacOvrEn), .dacOverride(dacOverride)
);

// File: tb/holdover_sequencer_test.sv
module holdover_sequencer_test;
  localparam int CODE_W = 10;
  localparam int WIN_W  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgHoldEn = 0, cfgLockTrig = 0, cfgLosTrig = 0, cfgLosDetEn = 0;
  logic cfgVtuneTrig = 0, cfgHitless = 0, cfgTrackEn = 0, cfgManualEn = 0;
  logic forceHold = 0, loopLocked = 1, refLost = 0;
  logic [CODE_W-1:0] tuneCode = 10'd500, tripLow = 10'd100, tripHigh = 10'd900;
  logic [CODE_W-1:0] manualCode = 10'd0;
  logic [WIN_W-1:0] alignWin = 4'd2;
  logic refPulse = 0, fbPulse = 0;
  logic holdActive, cpEnable, dacOvrEn;
  logic [CODE_W-1:0] dacOverride;

  always #10 clk = ~clk;  // 50 MHz

  holdover_sequencer #(.CODE_W(CODE_W), .WIN_W(WIN_W)) uut (.*);

  typedef struct {
    string tag;
    logic hold, cp, ovrEn;
    logic [CODE_W-1:0] ovr;
  } expItem_t;

  expItem_t expQ[$];
  int vecCnt = 0;
  int missCnt = 0;
  bit finished = 0;

  // driver: queue the outputs expected after the next edge, then move to the next negedge
  task automatic step(input string tag, input logic h, input logic c,
                      input logic oe, input logic [CODE_W-1:0] ov);
    expItem_t it;
    it.tag = tag; it.hold = h; it.cp = c; it.ovrEn = oe; it.ovr = ov;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compare 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        vecCnt++;
        if ({holdActive, cpEnable, dacOvrEn, dacOverride} !== {e.hold, e.cp, e.ovrEn, e.ovr}) begin
          missCnt++;
          $display("FAIL %s: got hold=%b cp=%b ovrEn=%b ovr=%0d, expected hold=%b cp=%b ovrEn=%b ovr=%0d",
                   e.tag, holdActive, cpEnable, dacOvrEn, dacOverride,
                   e.hold, e.cp, e.ovrEn, e.ovr);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!finished) begin
      missCnt++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step("R11 reset state", 0, 1, 0, 0);

    // R1: nothing enters while master enable is off
    cfgLockTrig = 1; loopLocked = 0; forceHold = 1;
    step("R1 disabled", 0, 1, 0, 0);
    forceHold = 0; loopLocked = 1;

    // R7 capture 321 while locked
    cfgHoldEn = 1; cfgTrackEn = 1; tuneCode = 10'd321;
    step("R7 capture", 0, 1, 0, 0);
    // R2 lock loss, code changes in the entry cycle and must not be captured
    loopLocked = 0; tuneCode = 10'd777;
    step("R2 lock loss entry", 1, 0, 1, 10'd321);
    tuneCode = 10'd50;
    step("R7 tracked held", 1, 0, 1, 10'd321);
    // R9 plain exit
    loopLocked = 1; tuneCode = 10'd500;
    step("R9 plain exit", 0, 1, 0, 0);
    step("R7 recapture", 0, 1, 0, 0);

    // R5 force, R8 manual priority
    cfgManualEn = 1; manualCode = 10'd612; forceHold = 1;
    step("R5 R8 force manual", 1, 0, 1, 10'd612);
    cfgManualEn = 0;
    step("R7 tracked after manual", 1, 0, 1, 10'd500);
    cfgTrackEn = 0;
    step("R8 no override mode", 1, 0, 0, 0);
    forceHold = 0;
    step("R9 exit after force", 0, 1, 0, 0);

    // R2 option off
    cfgLockTrig = 0; loopLocked = 0;
    step("R2 option off", 0, 1, 0, 0);
    loopLocked = 1;

    // R3 reference loss needs detector enable
    cfgLosTrig = 1; refLost = 1;
    step("R3 detector off", 0, 1, 0, 0);
    cfgLosDetEn = 1;
    step("R3 entry", 1, 0, 0, 0);
    refLost = 0;
    step("R3 exit", 0, 1, 0, 0);
    cfgLosTrig = 0;

    // R4 window edges
    cfgVtuneTrig = 1;
    tuneCode = 10'd100; step("R4 at low", 0, 1, 0, 0);
    tuneCode = 10'd900; step("R4 at high", 0, 1, 0, 0);
    tuneCode = 10'd99;  step("R4 below low", 1, 0, 0, 0);
    tuneCode = 10'd500; step("R4 back in", 0, 1, 0, 0);
    tuneCode = 10'd901; step("R4 above high", 1, 0, 0, 0);
    tuneCode = 10'd500; step("R4 back in 2", 0, 1, 0, 0);
    cfgVtuneTrig = 0;

    // R10 hitless exit, window 2
    cfgHitless = 1; forceHold = 1;
    step("R10 enter", 1, 0, 0, 0);
    forceHold = 0;
    step("R10 wait", 1, 0, 0, 0);
    refPulse = 1; step("R10 ref only", 1, 0, 0, 0);
    refPulse = 0; step("R10 idle a", 1, 0, 0, 0);
    step("R10 idle b", 1, 0, 0, 0);
    fbPulse = 1; step("R10 gap three", 1, 0, 0, 0);
    fbPulse = 0; step("R10 idle c", 1, 0, 0, 0);
    refPulse = 1; step("R10 gap two", 0, 1, 0, 0);
    refPulse = 0;

    // R10 trigger during wait, then coincident pulses
    forceHold = 1; step("R10 enter again", 1, 0, 0, 0);
    forceHold = 0; step("R10 wait again", 1, 0, 0, 0);
    forceHold = 1; step("R10 retrigger", 1, 0, 0, 0);
    refPulse = 1; fbPulse = 1; step("R10 held by trigger", 1, 0, 0, 0);
    refPulse = 0; fbPulse = 0; forceHold = 0;
    step("R10 wait third", 1, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R10 idle wait", 1, 0, 0, 0);
    refPulse = 1; fbPulse = 1; step("R10 coincident", 0, 1, 0, 0);
    refPulse = 0; fbPulse = 0;

    // R1: drop master enable while in holdover, hitless off
    cfgHitless = 0; forceHold = 1;
    step("R5 entry", 1, 0, 0, 0);
    cfgHoldEn = 0;
    step("R1 enable dropped", 0, 1, 0, 0);
    step("R1 stays locked", 0, 1, 0, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end
endmodule